// File: doc/BRIEF.md
# Chained Descriptor DMA Channel Sequencer

This block is the control half of one DMA channel. Once software starts it, the channel fetches a chain of transfer descriptors from memory on its own, one 32-bit word per handshake. Each descriptor is six words: config, source address, destination address, byte length, parameter, next-descriptor address. The channel presents each descriptor to an external data mover and counts down the bytes the mover reports. When the count reaches zero it moves on to the descriptor at the next address. The chain ends at a descriptor whose next address is the end marker 0xFFFFF800.

Software controls the channel through a small register window. There is a run/stop control, a pause control, the address of the first descriptor, and read-only views of the descriptor most recently loaded, including the bytes still to move. Three one-cycle event outputs mark half-way progress, the end of each descriptor and the end of the whole chain. The data mover and the arbitration of the memory port lie outside this block.

Top module: `lldma_chan`

## Requirements
- R1: After reset, every register offset reads 0. `mem_req`, `mv_valid`, `evt_half`, `evt_pkt` and `evt_queue` are low.
- R2: Writing 1 to bit 0 at offset 0x00 while the channel is idle starts a fetch at the programmed first address, with its low two bits cleared. Words are read at ascending addresses with a step of 4, and every `mem_addr` is 4-byte aligned. Bit 0 at offset 0x00 reads 1 while the channel is active.
- R3: Once a descriptor is fetched with a valid config and a nonzero length, `mv_valid` rises. `mv_cfg`, `mv_src`, `mv_dst` and `mv_para` carry words 0, 1, 2 and 4 of that descriptor. Each accepted `mv_ack` lowers the remaining count by `mv_nbytes`, saturating at 0. The descriptor is complete when the count reaches 0.
- R4: `evt_pkt` pulses for one cycle in the cycle after a descriptor completes. A zero-length descriptor completes directly after its fetch and never raises `mv_valid`.
- R5: If the completed descriptor's next word is not 0xFFFFF800, the channel fetches the descriptor at that address with bits 1:0 cleared. If it equals 0xFFFFF800, `evt_queue` pulses together with `evt_pkt` and bit 0 at offset 0x00 reads 0 from then on.
- R6: For a descriptor of nonzero length L, `evt_half` pulses exactly once. It fires in the cycle after the remaining count first falls to floor(L/2) or below.
- R7: Bit 1 at offset 0x04 is the pause control and reads back as written. While it is set, `mem_req` and `mv_valid` stay low and the remaining count does not change. Clearing it resumes the chain where it stopped.
- R8: Writing 0 to bit 0 at offset 0x00 returns the channel to idle at the next clock edge, with no event pulse. Descriptor words fetched but not yet loaded are discarded, so the read-back registers keep their previous values.
- R9: A descriptor whose source burst code (bits 8:7) or destination burst code (bits 24:23) is 1 or 3, or whose source width code (bits 10:9) or destination width code (bits 26:25) is 3, sends the channel to idle. It raises no event and never asserts `mv_valid`.
- R10: The read-back offsets are: 0x08, the first address with its low two bits cleared; 0x0C, config; 0x10, source; 0x14, destination; 0x18, remaining count; 0x1C, parameter. Offsets 0x0C to 0x1C show the descriptor most recently loaded. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset within the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read accepted; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| mv_valid | output | 1 | A descriptor is offered to the data mover |
| mv_cfg | output | 32 | Config word of the active descriptor |
| mv_src | output | 32 | Source address of the active descriptor |
| mv_dst | output | 32 | Destination address of the active descriptor |
| mv_para | output | 32 | Parameter word of the active descriptor |
| mv_ack | input | 1 | Mover reports progress this cycle |
| mv_nbytes | input | NB_W | Bytes moved in this progress report |
| evt_half | output | 1 | Half-way pulse |
| evt_pkt | output | 1 | Descriptor-done pulse |
| evt_queue | output | 1 | Chain-done pulse |

## Verification
The assertions assume the memory raises `mem_ack` only in a cycle where `mem_req` is high, and that the mover reports progress only while it sees `mv_valid` high, always with a nonzero byte count. The bench drives both responders on the falling edge and decides on a stall or a progress report only from the `mem_req` and `mv_valid` values it samples there, so neither side answers a request that has been withdrawn. Progress reports carry random counts from 1 to 16 bytes. These may overshoot the remaining length, which exercises the saturating countdown without breaking the assumptions.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int DESC_WORDS = 6;
  localparam logic [31:0] END_MARK = 32'hFFFF_F800;

  localparam logic [5:0] OFS_RUN   = 6'h00;
  localparam logic [5:0] OFS_HOLD  = 6'h04;
  localparam logic [5:0] OFS_FIRST = 6'h08;
  localparam logic [5:0] OFS_CFG   = 6'h0C;
  localparam logic [5:0] OFS_SRC   = 6'h10;
  localparam logic [5:0] OFS_DST   = 6'h14;
  localparam logic [5:0] OFS_REM   = 6'h18;
  localparam logic [5:0] OFS_PARA  = 6'h1C;

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] len;
    logic [31:0] para;
    logic [31:0] nxt;
  } desc_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_XFER  = 2'd2
  } seq_st_t;

  // Burst codes 0 and 2 and width codes 0..2 are legal on both sides.
  function automatic logic cfg_ok(input logic [31:0] c);
    logic bad;
    bad = (c[8:7] == 2'd1) || (c[8:7] == 2'd3) ||
          (c[24:23] == 2'd1) || (c[24:23] == 2'd3) ||
          (c[10:9] == 2'd3) || (c[26:25] == 2'd3);
    return !bad;
  endfunction

endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        running,
  input  desc_t       cur,
  input  logic [31:0] rem,
  output logic        start,
  output logic        stop,
  output logic        pause,
  output logic [31:0] first_addr
);

  logic [31:0] first_q, first_d;
  logic        pause_q, pause_d;
  logic        first_en, pause_en;

  assign first_en = reg_we && (reg_addr == OFS_FIRST);
  assign pause_en = reg_we && (reg_addr == OFS_HOLD);
  assign start    = reg_we && (reg_addr == OFS_RUN) && reg_wdata[0];
  assign stop     = reg_we && (reg_addr == OFS_RUN) && !reg_wdata[0];

  always_comb begin
    first_d = {reg_wdata[31:2], 2'b00};
    pause_d = reg_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      pause_q <= 1'b0;
    end else begin
      if (first_en) first_q <= first_d;
      if (pause_en) pause_q <= pause_d;
    end
  end

  assign pause      = pause_q;
  assign first_addr = first_q;

  always_comb begin
    case (reg_addr)
      OFS_RUN:   reg_rdata = {31'd0, running};
      OFS_HOLD:  reg_rdata = {30'd0, pause_q, 1'b0};
      OFS_FIRST: reg_rdata = first_q;
      OFS_CFG:   reg_rdata = cur.cfg;
      OFS_SRC:   reg_rdata = cur.src;
      OFS_DST:   reg_rdata = cur.dst;
      OFS_REM:   reg_rdata = rem;
      OFS_PARA:  reg_rdata = cur.para;
      default:   reg_rdata = '0;
    endcase
  end

  p_first_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    first_en |=> (first_addr[1:0] == 2'b00));

endmodule

// File: rtl/lldma_fetch.sv
module lldma_fetch
  import lldma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base,
  input  logic        abort,
  input  logic        hold,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output desc_t       desc,
  output logic        done
);

  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      base_q, base_d;
  logic             done_q, done_d;
  logic             take;
  logic [DESC_WORDS-1:0][31:0] words;

  assign mem_req  = busy_q && !hold;
  assign mem_addr = base_q + {{(30-IDX_W){1'b0}}, idx_q, 2'b00};
  assign take     = mem_req && mem_ack;

  generate
    for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_word
      logic [31:0] w_q;
      logic        w_en;
      assign w_en = take && (idx_q == IDX_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w_q <= '0;
        else if (w_en) w_q <= mem_rdata;
      end
      assign words[gi] = w_q;
    end
  endgenerate

  always_comb begin
    desc.cfg  = words[0];
    desc.src  = words[1];
    desc.dst  = words[2];
    desc.len  = words[3];
    desc.para = words[4];
    desc.nxt  = words[5];
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    base_d = base_q;
    done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      base_d = base;
    end else if (take) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!mem_req && !done));

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
#(
  parameter int NB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            pause,
  input  logic [31:0]     first_addr,
  input  logic            fetch_done,
  input  desc_t           desc,
  output logic            fetch_start,
  output logic [31:0]     fetch_base,
  input  logic            mv_ack,
  input  logic [NB_W-1:0] mv_nbytes,
  output logic            running,
  output logic            xfer_live,
  output desc_t           cur,
  output logic [31:0]     rem,
  output logic            evt_half,
  output logic            evt_pkt,
  output logic            evt_queue
);

  seq_st_t     st_q, st_d;
  desc_t       cur_q, cur_d;
  logic [31:0] rem_q, rem_d, rem_sub, nb_ext, half_lvl, nxt_v;
  logic        half_q, half_d, pkt_q, pkt_d, queue_q, queue_d;
  logic        done_now;

  assign nb_ext   = 32'(mv_nbytes);
  assign half_lvl = cur_q.len >> 1;
  assign rem_sub  = (nb_ext >= rem_q) ? 32'd0 : (rem_q - nb_ext);

  always_comb begin
    st_d        = st_q;
    cur_d       = cur_q;
    rem_d       = rem_q;
    half_d      = 1'b0;
    pkt_d       = 1'b0;
    queue_d     = 1'b0;
    done_now    = 1'b0;
    fetch_start = 1'b0;
    fetch_base  = first_addr;
    nxt_v       = cur_q.nxt;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d        = S_FETCH;
          fetch_start = 1'b1;
        end
      end
      S_FETCH: begin
        if (stop) begin
          st_d = S_IDLE;
        end else if (fetch_done) begin
          cur_d = desc;
          nxt_v = desc.nxt;
          if (!cfg_ok(desc.cfg)) begin
            st_d = S_IDLE;
          end else if (desc.len == 32'd0) begin
            rem_d    = '0;
            done_now = 1'b1;
          end else begin
            rem_d = desc.len;
            st_d  = S_XFER;
          end
        end
      end
      S_XFER: begin
        if (stop) begin
          st_d = S_IDLE;
        end else if (!pause && mv_ack) begin
          rem_d = rem_sub;
          if ((rem_q > half_lvl) && (rem_sub <= half_lvl)) half_d = 1'b1;
          if (rem_sub == 32'd0) done_now = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (done_now) begin
      pkt_d = 1'b1;
      if (nxt_v == END_MARK) begin
        queue_d = 1'b1;
        st_d    = S_IDLE;
      end else begin
        st_d        = S_FETCH;
        fetch_start = 1'b1;
        fetch_base  = {nxt_v[31:2], 2'b00};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      half_q  <= 1'b0;
      pkt_q   <= 1'b0;
      queue_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      rem_q   <= rem_d;
      half_q  <= half_d;
      pkt_q   <= pkt_d;
      queue_q <= queue_d;
    end
  end

  assign running   = (st_q != S_IDLE);
  assign xfer_live = (st_q == S_XFER) && !pause;
  assign cur       = cur_q;
  assign rem       = rem_q;
  assign evt_half  = half_q;
  assign evt_pkt   = pkt_q;
  assign evt_queue = queue_q;

  p_queue_with_pkt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_queue |-> evt_pkt);

  p_pkt_rem_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pkt |-> (rem_q == 32'd0));

  p_pause_holds_rem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_XFER) && pause && !stop) |=> $stable(rem_q));

  p_stop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running && !evt_pkt && !evt_queue && !evt_half));

  p_bad_cfg_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_FETCH) && fetch_done && !stop && !cfg_ok(desc.cfg))
      |=> (!running && !evt_pkt));

endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int NB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [5:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            mv_valid,
  output logic [31:0]     mv_cfg,
  output logic [31:0]     mv_src,
  output logic [31:0]     mv_dst,
  output logic [31:0]     mv_para,
  input  logic            mv_ack,
  input  logic [NB_W-1:0] mv_nbytes,
  output logic            evt_half,
  output logic            evt_pkt,
  output logic            evt_queue
);

  logic        start, stop, pause, running;
  logic [31:0] first_addr, fetch_base, rem;
  logic        fetch_start, fetch_done;
  desc_t       fdesc, cur;

  lldma_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .running    (running),
    .cur        (cur),
    .rem        (rem),
    .start      (start),
    .stop       (stop),
    .pause      (pause),
    .first_addr (first_addr)
  );

  lldma_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fetch_start),
    .base      (fetch_base),
    .abort     (stop),
    .hold      (pause),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .desc      (fdesc),
    .done      (fetch_done)
  );

  lldma_seq #(.NB_W(NB_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .stop        (stop),
    .pause       (pause),
    .first_addr  (first_addr),
    .fetch_done  (fetch_done),
    .desc        (fdesc),
    .fetch_start (fetch_start),
    .fetch_base  (fetch_base),
    .mv_ack      (mv_ack),
    .mv_nbytes   (mv_nbytes),
    .running     (running),
    .xfer_live   (mv_valid),
    .cur         (cur),
    .rem         (rem),
    .evt_half    (evt_half),
    .evt_pkt     (evt_pkt),
    .evt_queue   (evt_queue)
  );

  assign mv_cfg  = cur.cfg;
  assign mv_src  = cur.src;
  assign mv_dst  = cur.dst;
  assign mv_para = cur.para;

endmodule

// File: tb/lldma_chan_test.sv
module lldma_chan_test;

  localparam int NB_W = 8;
  localparam logic [31:0] ENDM = 32'hFFFF_F800;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            reg_we;
  logic [5:0]      reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic            mem_req, mem_ack, mem_stall;
  logic [31:0]     mem_addr, mem_rdata;
  logic            mv_valid, mv_ack;
  logic [31:0]     mv_cfg, mv_src, mv_dst, mv_para;
  logic [NB_W-1:0] mv_nbytes;
  logic            evt_half, evt_pkt, evt_queue;

  lldma_chan #(.NB_W(NB_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_valid(mv_valid), .mv_cfg(mv_cfg), .mv_src(mv_src), .mv_dst(mv_dst),
    .mv_para(mv_para), .mv_ack(mv_ack), .mv_nbytes(mv_nbytes),
    .evt_half(evt_half), .evt_pkt(evt_pkt), .evt_queue(evt_queue)
  );

  int n_checks = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [0:255];
  bit stall_force = 1'b0;
  always @(negedge clk) mem_stall <= stall_force || ($urandom_range(0, 3) == 0);
  assign mem_ack   = mem_req && !mem_stall;
  assign mem_rdata = mem[mem_addr[9:2]];

  // expected descriptors and mover model
  logic [31:0] e_cfg [0:7];
  logic [31:0] e_src [0:7];
  logic [31:0] e_dst [0:7];
  logic [31:0] e_para[0:7];
  int          e_len [0:7];
  int didx, moved, last_nb, pkt_cnt, half_cnt, queue_cnt;
  bit saw_valid;

  always @(negedge clk) begin
    if (!rst_n) begin
      mv_ack = 1'b0;
      mv_nbytes = '0;
    end else begin
      if (mem_req) check(mem_addr[1:0] == 2'b00, "R2 aligned fetch", mem_addr, {mem_addr[31:2], 2'b00});
      if (evt_half) begin
        half_cnt++;
        check(moved >= e_len[didx & 7] - (e_len[didx & 7] >> 1) &&
              (moved - last_nb) < e_len[didx & 7] - (e_len[didx & 7] >> 1),
              "R6 half point", moved, e_len[didx & 7] - (e_len[didx & 7] >> 1));
      end
      if (evt_pkt) begin
        pkt_cnt++;
        if (e_len[didx & 7] == 0)
          check(moved == 0, "R4 zero length done", moved, 0);
        else
          check(moved >= e_len[didx & 7] && (moved - last_nb) < e_len[didx & 7],
                "R3 countdown done", moved, e_len[didx & 7]);
        moved = 0;
        didx++;
      end
      if (evt_queue) queue_cnt++;
      if (mv_valid) begin
        saw_valid = 1'b1;
        check(mv_cfg == e_cfg[didx & 7] && mv_src == e_src[didx & 7] &&
              mv_dst == e_dst[didx & 7] && mv_para == e_para[didx & 7],
              "R3 mover fields", mv_src, e_src[didx & 7]);
      end
      if (mv_valid && $urandom_range(0, 2) != 0) begin
        last_nb = $urandom_range(1, 16);
        mv_ack = 1'b1;
        mv_nbytes = NB_W'(last_nb);
        moved += last_nb;
      end else begin
        mv_ack = 1'b0;
        mv_nbytes = '0;
        last_nb = 0;
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] r);
    @(negedge clk);
    reg_addr = a;
    #1 r = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 4000; i++) begin
      rd(6'h00, r);
      if (r[0] == 1'b0) break;
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (mv_valid) break;
    end
  endtask

  task automatic clr();
    didx = 0; moved = 0; last_nb = 0;
    pkt_cnt = 0; half_cnt = 0; queue_cnt = 0; saw_valid = 1'b0;
  endtask

  function automatic logic [15:0] mk_half(input logic [4:0] port, input bit io,
                                          input logic [1:0] b, input logic [1:0] w);
    return {5'd0, w, b, 1'b0, io, port};
  endfunction

  function automatic logic [31:0] rnd_cfg();
    logic [15:0] s, d;
    s = mk_half(5'($urandom), 1'($urandom), ($urandom_range(0, 1) != 0) ? 2'd2 : 2'd0, 2'($urandom_range(0, 2)));
    d = mk_half(5'($urandom), 1'($urandom), ($urandom_range(0, 1) != 0) ? 2'd2 : 2'd0, 2'($urandom_range(0, 2)));
    return {d, s};
  endfunction

  task automatic put_desc(input int k, input int slot, input logic [31:0] cfg, input logic [31:0] src,
                          input logic [31:0] dst, input int len, input logic [31:0] para,
                          input logic [31:0] nxt);
    mem[slot*8+0] = cfg;  mem[slot*8+1] = src;  mem[slot*8+2] = dst;
    mem[slot*8+3] = 32'(len); mem[slot*8+4] = para; mem[slot*8+5] = nxt;
    e_cfg[k] = cfg; e_src[k] = src; e_dst[k] = dst; e_len[k] = len; e_para[k] = para;
  endtask

  task automatic run_random(input int run);
    int n, nz, len;
    logic [31:0] cfg, nxt, r;
    n = $urandom_range(1, 4);
    nz = 0;
    for (int k = 0; k < n; k++) begin
      cfg = rnd_cfg();
      len = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 40);
      if (len != 0) nz++;
      nxt = (k == n - 1) ? ENDM : (32'(((k + 1) * 3 + run) * 32) | 32'($urandom_range(0, 3)));
      put_desc(k, k * 3 + run, cfg, $urandom, $urandom,
               len, ($urandom_range(0, 1) != 0) ? 32'd8 : $urandom, nxt);
    end
    clr();
    wr(6'h08, 32'(run * 32) | 32'($urandom_range(0, 3)));
    wr(6'h00, 32'd1);
    wait_idle();
    repeat (3) @(negedge clk);
    check(pkt_cnt == n, "R5 descriptors completed", pkt_cnt, n);
    check(queue_cnt == 1, "R5 chain end pulse", queue_cnt, 1);
    check(half_cnt == nz, "R6 half pulses", half_cnt, nz);
    rd(6'h0C, r); check(r == e_cfg[n-1], "R10 cfg readback", r, e_cfg[n-1]);
    rd(6'h10, r); check(r == e_src[n-1], "R10 src readback", r, e_src[n-1]);
    rd(6'h14, r); check(r == e_dst[n-1], "R10 dst readback", r, e_dst[n-1]);
    rd(6'h1C, r); check(r == e_para[n-1], "R10 para readback", r, e_para[n-1]);
    rd(6'h18, r); check(r == 0, "R10 remaining after end", r, 0);
  endtask

  task automatic run_bad(input logic [31:0] cfg);
    logic [31:0] r;
    put_desc(0, 25, cfg, 32'h1000, 32'h2000, 16, 32'd8, ENDM);
    clr();
    wr(6'h08, 32'(25 * 32));
    wr(6'h00, 32'd1);
    repeat (40) @(negedge clk);
    rd(6'h00, r); check(r[0] == 1'b0, "R9 bad config idles", r, 0);
    check(pkt_cnt == 0 && queue_cnt == 0 && half_cnt == 0, "R9 no events", pkt_cnt, 0);
    check(!saw_valid, "R9 mover never offered", 32'(saw_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r, prev_cfg;
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    clr();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(6'(a * 4), r);
      check(r == 0, "R1 register reset value", r, 0);
    end
    check(!mem_req && !mv_valid && !evt_half && !evt_pkt && !evt_queue, "R1 outputs idle",
          {27'd0, mem_req, mv_valid, evt_half, evt_pkt, evt_queue}, 0);

    // R10 first address alignment and unmapped read
    wr(6'h08, 32'h0000_0123);
    rd(6'h08, r); check(r == 32'h0000_0120, "R10 first address aligned", r, 32'h120);
    rd(6'h20, r); check(r == 0, "R10 unmapped offset", r, 0);

    // R4 single zero-length descriptor
    put_desc(0, 20, {16'h0000, mk_half(5'd1, 1'b0, 2'd2, 2'd2)}, 32'hA0, 32'hB0, 0, 32'd8, ENDM);
    clr();
    wr(6'h08, 32'(20 * 32));
    wr(6'h00, 32'd1);
    rd(6'h00, r); check(r[0] == 1'b1, "R2 active reads 1", r, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    check(pkt_cnt == 1 && queue_cnt == 1 && half_cnt == 0 && !saw_valid, "R4 zero length chain",
          pkt_cnt, 1);

    // random chains
    for (int run = 0; run < 12; run++) run_random(run);

    // R7 pause in the middle of a transfer
    put_desc(0, 29, {mk_half(5'd3, 1'b1, 2'd0, 2'd1), mk_half(5'd1, 1'b0, 2'd2, 2'd2)},
             32'h4000, 32'h5000, 300, 32'd8, ENDM);
    clr();
    wr(6'h08, 32'(29 * 32));
    wr(6'h00, 32'd1);
    wait_valid();
    wr(6'h04, 32'd2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!mv_valid && !mem_req, "R7 paused outputs low", {30'd0, mv_valid, mem_req}, 0);
    end
    rd(6'h18, r); check(r == 32'(300 - moved), "R7 remaining while paused", r, 32'(300 - moved));
    repeat (10) @(negedge clk);
    rd(6'h18, r); check(r == 32'(300 - moved), "R7 remaining frozen", r, 32'(300 - moved));
    rd(6'h04, r); check(r == 32'd2, "R7 pause readback", r, 2);
    wr(6'h04, 32'd0);
    wait_idle();
    repeat (2) @(negedge clk);
    check(pkt_cnt == 1 && queue_cnt == 1, "R7 resumed to completion", pkt_cnt, 1);

    // R7 pause set before start blocks fetching
    clr();
    wr(6'h04, 32'd2);
    wr(6'h00, 32'd1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!mem_req, "R7 no fetch while paused", {31'd0, mem_req}, 0);
    end
    rd(6'h00, r); check(r[0] == 1'b1, "R7 paused channel active", r, 1);
    wr(6'h04, 32'd0);
    wait_idle();
    repeat (2) @(negedge clk);
    check(pkt_cnt == 1 && queue_cnt == 1, "R7 completes after release", pkt_cnt, 1);

    // R8 stop while a fetch is outstanding
    rd(6'h0C, prev_cfg);
    put_desc(0, 24, 32'h0000_0042, 32'h7000, 32'h8000, 20, 32'd8, ENDM);
    clr();
    stall_force = 1'b1;
    wr(6'h08, 32'(24 * 32));
    wr(6'h00, 32'd1);
    repeat (3) @(negedge clk);
    stall_force = 1'b0;
    mem[24*8+0] = 32'h0000_0043;
    wr(6'h00, 32'd0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!mem_req && !mv_valid, "R8 stopped outputs low", {30'd0, mem_req, mv_valid}, 0);
    end
    rd(6'h00, r); check(r[0] == 1'b0, "R8 stop idles", r, 0);
    check(pkt_cnt == 0 && queue_cnt == 0 && half_cnt == 0, "R8 no events after stop", pkt_cnt, 0);
    rd(6'h0C, r); check(r == prev_cfg, "R8 fetched words discarded", r, prev_cfg);

    // R8 stop during a transfer
    put_desc(0, 24, 32'h0000_0042, 32'h7000, 32'h8000, 400, 32'd8, ENDM);
    clr();
    wr(6'h00, 32'd1);
    wait_valid();
    wr(6'h00, 32'd0);
    repeat (10) @(negedge clk);
    check(!mv_valid && pkt_cnt == 0 && queue_cnt == 0, "R8 transfer stopped silently", pkt_cnt, 0);
    rd(6'h00, r); check(r[0] == 1'b0, "R8 idle after stop", r, 0);

    // R9 unsupported codes
    run_bad({mk_half(5'd0, 1'b0, 2'd0, 2'd0), mk_half(5'd1, 1'b0, 2'd1, 2'd2)});
    run_bad({mk_half(5'd0, 1'b0, 2'd0, 2'd3), mk_half(5'd1, 1'b0, 2'd0, 2'd0)});
    run_bad({mk_half(5'd0, 1'b0, 2'd2, 2'd0), mk_half(5'd1, 1'b0, 2'd3, 2'd0)});
    run_bad({mk_half(5'd0, 1'b0, 2'd1, 2'd0), mk_half(5'd1, 1'b0, 2'd0, 2'd0)});

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule